// File: doc/BRIEF.md
# Parallel Flash Command Interpreter

This block behaves like a byte-addressed parallel NOR flash that is steered by written command bytes rather than by dedicated control pins. Its contents sit in an internal byte array. A single synchronous bus carries requests: address, write data, an access-size code, and registered read data that comes back one cycle after a read request. Writes are decoded into a one-bit "armed" cycle counter and a latched command code. That pair decides what the next write does and which source feeds the read data: array bytes, the status byte, identification codes or the query table.

Software programs a location by writing a program command and then the data. It erases a sector by writing an erase command, which clears the whole sector to 0xFF at once, followed by a confirm byte. A status byte reports progress through sticky bits: bit 7 ready, bit 5 erase error and bit 4 program error. Only the clear-status command resets it. A write-protect input stands in for a read-only array. Lock and unlock sequences are accepted and change nothing. Sector size, array size, bus width, device lane width, identification codes and byte order are parameters.

Top module: `pfc_flash`

## Requirements
- R1: A write of 0xFF, 0x00 or 0xF0 while not armed selects read-array mode. Reads then return array bytes, with lane k holding the byte at address+k (addresses wrap modulo the array size).
- R2: A write of 0x10 or 0x40 arms a program. The next write stores its low 1, 2 or 4 bytes (size code 0, 1, 2) at its address, lane k at address+k. It also sets status bit 7, disarms, and leaves reads returning status.
- R3: A write of 0x20 at once sets to 0xFF every byte of the 2^SECT_W-byte sector whose base is the address with its low SECT_W bits cleared, and arms. The next write of 0xD0 disarms and keeps status reads. Any other next value, 0xFF included, returns to read-array mode.
- R4: With wp_i high, the program data cycle sets status bit 4 and an erase command sets status bit 5. In both cases the array is left unchanged and bit 7 is set. Error bits stay set until cleared.
- R5: A write of 0x50 while not armed sets the status byte to 0x00 and selects read-array mode.
- R6: A write of 0x70 latches status mode without arming. In status mode the status byte is returned in every lane whose index is a multiple of DEV_BYTES, up to the access size. The same holds after program, erase or lock commands.
- R7: A write of 0x90 latches identification mode without arming. A read with word index address>>log2(BUS_BYTES) of 0 returns MFR_ID, index 1 returns DEV_ID, and any other index returns 0. The low DEV_BYTES bytes of the code are repeated in every device lane.
- R8: A write of 0x98 arms query mode. The word index 0x10, 0x11 and 0x12 returns 0x51, 0x52 and 0x59. Index 0x13 returns 0x01, 0x27 returns ADDR_W, and 0x2C returns 0x01. Index 0x2D and 0x2E return the low and high bytes of the sector count minus one, and every other index returns 0. A written 0xFF leaves query mode, and any other written value keeps it.
- R9: A write of 0x60 arms a lock sequence. A second write of 0xD0 or 0x01 disarms, sets bit 7 and keeps status reads. Any other second value returns to read-array mode. The array is never changed by this sequence.
- R10: An unrecognised command byte (for example 0x33 or 0xE8) selects read-array mode and leaves the status byte unchanged.
- R11: After reset the status byte is 0x80, read-array mode is selected and bus_rvalid and bus_rdata are 0. Each read request gives bus_rvalid and its data on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = BUS_BYTES |
| bus_wdata | input | 8*BUS_BYTES | Write data; the low byte is the command code |
| wp_i | input | 1 | Array write protect |
| bus_rdata | output | 8*BUS_BYTES | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The program data cycle has two outcomes that are decided in the same cycle: the array update and the write-protect error. The bench raises wp_i at random on exactly that cycle and on the erase command cycle. It then reads the status byte, reads the array back, and compares both against a reference model that applies either the write or the error bit, never both. Erases that hit a sector holding freshly programmed words are mixed into the same random stream. This checks that the one-cycle sector clear and the lane-wise program never interfere.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  localparam logic [7:0] OP_ARRAY_RST = 8'h00;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLR_STAT  = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_LOCK_ALT  = 8'h01;
  localparam logic [7:0] OP_EXIT_A    = 8'hF0;
  localparam logic [7:0] OP_EXIT_B    = 8'hFF;

  localparam int ST_READY = 7;
  localparam int ST_ERASE_ERR = 5;
  localparam int ST_PROG_ERR = 4;

  typedef enum logic [1:0] {
    RSEL_ARRAY  = 2'd0,
    RSEL_STATUS = 2'd1,
    RSEL_IDENT  = 2'd2,
    RSEL_QUERY  = 2'd3
  } rsel_e;

  function automatic logic [7:0] qry_lookup(input int idx, input int aw, input int sw);
    int nsect_m1;
    nsect_m1 = (1 << (aw - sw)) - 1;
    case (idx)
      16'h10:  return 8'h51;
      16'h11:  return 8'h52;
      16'h12:  return 8'h59;
      16'h13:  return 8'h01;
      16'h27:  return 8'(aw);
      16'h2C:  return 8'h01;
      16'h2D:  return 8'(nsect_m1);
      16'h2E:  return 8'(nsect_m1 >> 8);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pfc_cmd_ctrl.sv
module pfc_cmd_ctrl
  import pfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_byte,
  input  logic       wp,
  output logic [7:0] cmd_q,
  output logic       armed_q,
  output logic [7:0] status_q,
  output logic       prog_go,
  output logic       erase_go,
  output rsel_e      rsel
);

  logic [7:0] cmd_d;
  logic       armed_d;
  logic [7:0] status_d;

  // next-state decode
  always_comb begin
    cmd_d    = cmd_q;
    armed_d  = armed_q;
    status_d = status_q;
    prog_go  = 1'b0;
    erase_go = 1'b0;
    if (wr_en) begin
      if (!armed_q) begin
        case (wr_byte)
          OP_ARRAY_RST, OP_EXIT_A, OP_EXIT_B: begin
            cmd_d   = OP_ARRAY_RST;
            armed_d = 1'b0;
          end
          OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
            cmd_d   = wr_byte;
            armed_d = 1'b1;
          end
          OP_ERASE: begin
            cmd_d   = OP_ERASE;
            armed_d = 1'b1;
            if (wp) status_d[ST_ERASE_ERR] = 1'b1;
            else    erase_go = 1'b1;
            status_d[ST_READY] = 1'b1;
          end
          OP_CLR_STAT: begin
            status_d = 8'h00;
            cmd_d    = OP_ARRAY_RST;
          end
          OP_STATUS, OP_IDENT: begin
            cmd_d = wr_byte;
          end
          default: begin
            cmd_d   = OP_ARRAY_RST;
            armed_d = 1'b0;
          end
        endcase
      end else begin
        armed_d = 1'b0;
        case (cmd_q)
          OP_PROG_A, OP_PROG_B: begin
            if (wp) status_d[ST_PROG_ERR] = 1'b1;
            else    prog_go = 1'b1;
            status_d[ST_READY] = 1'b1;
          end
          OP_ERASE: begin
            if (wr_byte == OP_CONFIRM) status_d[ST_READY] = 1'b1;
            else                       cmd_d = OP_ARRAY_RST;
          end
          OP_LOCK: begin
            if (wr_byte == OP_CONFIRM || wr_byte == OP_LOCK_ALT) status_d[ST_READY] = 1'b1;
            else                                                   cmd_d = OP_ARRAY_RST;
          end
          OP_QUERY: begin
            if (wr_byte == OP_EXIT_B) cmd_d = OP_ARRAY_RST;
            else                      armed_d = 1'b1;
          end
          default: begin
            cmd_d = OP_ARRAY_RST;
          end
        endcase
      end
    end
  end

  always_comb begin
    case (cmd_q)
      OP_ARRAY_RST: rsel = RSEL_ARRAY;
      OP_IDENT:     rsel = RSEL_IDENT;
      OP_QUERY:     rsel = RSEL_QUERY;
      default:      rsel = RSEL_STATUS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= OP_ARRAY_RST;
      armed_q  <= 1'b0;
      status_q <= 8'h80;
    end else if (wr_en) begin
      cmd_q    <= cmd_d;
      armed_q  <= armed_d;
      status_q <= status_d;
    end
  end

  AST_EXIT_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && (wr_byte == 8'hFF || wr_byte == 8'h00 || wr_byte == 8'hF0))
    |=> (rsel == RSEL_ARRAY && !armed_q)); // R1

  AST_PROG_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed_q && (cmd_q == 8'h10 || cmd_q == 8'h40))
    |=> (!armed_q && status_q[7] && rsel == RSEL_STATUS)); // R2

  AST_ERASE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && wr_byte == 8'h20 && wp)
    |=> (status_q[5] && status_q[7] && !$past(erase_go))); // R4

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && wr_byte == 8'h50)
    |=> (status_q == 8'h00 && rsel == RSEL_ARRAY)); // R5

  AST_LATCH_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && (wr_byte == 8'h70 || wr_byte == 8'h90))
    |=> (!armed_q && cmd_q == $past(wr_byte))); // R6

  AST_STICKY_ERRORS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !armed_q && wr_byte == 8'h50)
    |=> ((status_q & 8'hB0) & $past(status_q & 8'hB0)) == $past(status_q & 8'hB0)); // R4

endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
  parameter int ADDR_W    = 8,
  parameter int SECT_W    = 4,
  parameter int BUS_BYTES = 4,
  parameter bit BIG_END   = 1'b0,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int DW       = BUS_BYTES * 8,
  localparam int NBW      = $clog2(BUS_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_go,
  input  logic              erase_go,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBW-1:0]    nbytes,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rd_word
);

  logic [7:0] mem_q [DEPTH];
  logic [7:0] mem_d [DEPTH];
  logic [BUS_BYTES-1:0][7:0] lane_wr;
  logic [ADDR_W-1:0] sect_base;
  logic mem_en;

  assign sect_base = (addr >> SECT_W) << SECT_W;
  assign mem_en    = prog_go | erase_go;

  // byte order selection per lane
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_lane
    if (BIG_END) begin : g_be
      assign lane_wr[k] = (NBW'(k) < nbytes) ? wdata[(int'(nbytes) - k - 1) * 8 +: 8] : 8'h00;
      assign rd_word[k*8 +: 8] = (NBW'(k) < nbytes) ?
        mem_q[addr + ADDR_W'(int'(nbytes) - k - 1)] : 8'h00;
    end else begin : g_le
      assign lane_wr[k] = wdata[k*8 +: 8];
      assign rd_word[k*8 +: 8] = (NBW'(k) < nbytes) ? mem_q[addr + ADDR_W'(k)] : 8'h00;
    end
  end

  // next array content
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (erase_go && ((ADDR_W'(i) >> SECT_W) == (addr >> SECT_W))) begin
        mem_d[i] = 8'hFF;
      end
      if (prog_go) begin
        for (int k = 0; k < BUS_BYTES; k++) begin
          if (NBW'(k) < nbytes && (addr + ADDR_W'(k)) == ADDR_W'(i)) begin
            mem_d[i] = lane_wr[k];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mem_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= mem_d[i];
      end
    end
  end

  AST_ERASE_FILLS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem_q[$past(sect_base)] == 8'hFF)); // R3

  AST_ERASE_FILLS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |=> (mem_q[$past(sect_base) | ADDR_W'((1 << SECT_W) - 1)] == 8'hFF)); // R3

  AST_ONE_ARRAY_OP: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_go && erase_go)); // R2

  AST_PROG_FIRST_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_go && !BIG_END) |=> (mem_q[$past(addr)] == $past(wdata[7:0]))); // R2

endmodule

// File: rtl/pfc_rdpath.sv
module pfc_rdpath
  import pfc_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int SECT_W          = 4,
  parameter int BUS_BYTES       = 4,
  parameter int DEV_BYTES       = 1,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h0018,
  localparam int DW             = BUS_BYTES * 8,
  localparam int NBW            = $clog2(BUS_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  rsel_e             rsel,
  input  logic [ADDR_W-1:0] widx,
  input  logic [NBW-1:0]    nbytes,
  input  logic [7:0]        status,
  input  logic [DW-1:0]     arr_word,
  output logic [DW-1:0]     rdata_q,
  output logic              rvalid_q
);

  logic [15:0] id_val;
  logic [7:0]  qry_b;
  logic [DW-1:0] rdata_d;

  always_comb begin
    if (widx == '0)                  id_val = MFR_ID;
    else if (widx == ADDR_W'(1))     id_val = DEV_ID;
    else                             id_val = 16'h0000;
    qry_b = qry_lookup(int'(widx), ADDR_W, SECT_W);
  end

  // lane replication per device
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_out
    localparam int DL = k % DEV_BYTES;
    logic [7:0] stat_b;
    logic [7:0] id_b;
    logic [7:0] q_b;
    logic [7:0] sel_b;
    assign stat_b = (DL == 0) ? status : 8'h00;
    assign id_b   = id_val[DL*8 +: 8];
    assign q_b    = (DL == 0) ? qry_b : 8'h00;
    always_comb begin
      case (rsel)
        RSEL_ARRAY:  sel_b = arr_word[k*8 +: 8];
        RSEL_STATUS: sel_b = stat_b;
        RSEL_IDENT:  sel_b = id_b;
        default:     sel_b = q_b;
      endcase
    end
    assign rdata_d[k*8 +: 8] = (NBW'(k) < nbytes) ? sel_b : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid_q); // R11

  AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid_q); // R11

  AST_STATUS_LANE0: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rsel == RSEL_STATUS) |=> (rdata_q[7:0] == $past(status))); // R6

endmodule

// File: rtl/pfc_flash.sv
module pfc_flash
  import pfc_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int SECT_W          = 4,
  parameter int BUS_BYTES       = 4,
  parameter int DEV_BYTES       = 1,
  parameter bit BIG_END         = 1'b0,
  parameter logic [15:0] MFR_ID = 16'h0089,
  parameter logic [15:0] DEV_ID = 16'h0018,
  localparam int DW             = BUS_BYTES * 8,
  localparam int NBW            = $clog2(BUS_BYTES) + 1,
  localparam int LANE_SH        = $clog2(BUS_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              wp_i,
  output logic [DW-1:0]     bus_rdata,
  output logic              bus_rvalid
);

  logic             wr_en;
  logic             rd_en;
  logic [NBW-1:0]   nbytes;
  logic [ADDR_W-1:0] widx;
  logic [7:0]       cmd_q;
  logic             armed_q;
  logic [7:0]       status_q;
  logic             prog_go;
  logic             erase_go;
  rsel_e            rsel;
  logic [DW-1:0]    arr_word;

  assign wr_en = bus_req & bus_we;
  assign rd_en = bus_req & ~bus_we;
  assign widx  = bus_addr >> LANE_SH;

  always_comb begin
    case (bus_size)
      2'd0:    nbytes = NBW'(1);
      2'd1:    nbytes = (BUS_BYTES >= 2) ? NBW'(2) : NBW'(BUS_BYTES);
      default: nbytes = NBW'(BUS_BYTES);
    endcase
  end

  pfc_cmd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_byte  (bus_wdata[7:0]),
    .wp       (wp_i),
    .cmd_q    (cmd_q),
    .armed_q  (armed_q),
    .status_q (status_q),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .rsel     (rsel)
  );

  pfc_array #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .BUS_BYTES (BUS_BYTES),
    .BIG_END   (BIG_END)
  ) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_go  (prog_go),
    .erase_go (erase_go),
    .addr     (bus_addr),
    .nbytes   (nbytes),
    .wdata    (bus_wdata),
    .rd_word  (arr_word)
  );

  pfc_rdpath #(
    .ADDR_W    (ADDR_W),
    .SECT_W    (SECT_W),
    .BUS_BYTES (BUS_BYTES),
    .DEV_BYTES (DEV_BYTES),
    .MFR_ID    (MFR_ID),
    .DEV_ID    (DEV_ID)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rsel     (rsel),
    .widx     (widx),
    .nbytes   (nbytes),
    .status   (status_q),
    .arr_word (arr_word),
    .rdata_q  (bus_rdata),
    .rvalid_q (bus_rvalid)
  );

  AST_UNKNOWN_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !armed_q && (bus_wdata[7:0] == 8'h33 || bus_wdata[7:0] == 8'hE8))
    |=> (status_q == $past(status_q) && cmd_q == 8'h00)); // R10

  AST_LOCK_NO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && armed_q && cmd_q == 8'h60) |-> (!prog_go && !erase_go)); // R9

endmodule

// File: tb/pfc_flash_tb.sv
module pfc_flash_tb;

  localparam int AW = 8;
  localparam int SW = 4;
  localparam logic [15:0] MFR = 16'h0089;
  localparam logic [15:0] DID = 16'h0018;

  logic        clk;
  logic        rst_n;
  logic        bus_req;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic [31:0] bus_wdata;
  logic        wp_i;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;

  int checks;
  int errors;

  // reference state
  logic [7:0] mem_m [256];
  logic [7:0] cmd_m;
  logic       arm_m;
  logic [7:0] st_m;

  pfc_flash u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .wp_i       (wp_i),
    .bus_rdata  (bus_rdata),
    .bus_rvalid (bus_rvalid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] qry_ref(input int idx);
    case (idx)
      'h10: return 8'h51;
      'h11: return 8'h52;
      'h12: return 8'h59;
      'h13: return 8'h01;
      'h27: return 8'(AW);
      'h2C: return 8'h01;
      'h2D: return 8'((1 << (AW - SW)) - 1);
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_wr(input logic [7:0] a, input logic [31:0] d,
                                   input logic [1:0] sz, input logic wp);
    int nb;
    logic [7:0] c;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    c = d[7:0];
    if (!arm_m) begin
      if (c == 8'hFF || c == 8'h00 || c == 8'hF0) begin cmd_m = 0; end
      else if (c == 8'h10 || c == 8'h40 || c == 8'h60 || c == 8'h98) begin cmd_m = c; arm_m = 1; end
      else if (c == 8'h20) begin
        cmd_m = c; arm_m = 1;
        if (wp) st_m[5] = 1'b1;
        else for (int i = 0; i < 16; i++) mem_m[{a[7:4], 4'(i)}] = 8'hFF;
        st_m[7] = 1'b1;
      end
      else if (c == 8'h50) begin st_m = 0; cmd_m = 0; end
      else if (c == 8'h70 || c == 8'h90) cmd_m = c;
      else cmd_m = 0;
    end else begin
      arm_m = 0;
      if (cmd_m == 8'h10 || cmd_m == 8'h40) begin
        if (wp) st_m[4] = 1'b1;
        else for (int k = 0; k < nb; k++) mem_m[8'(a + k)] = d[k*8 +: 8];
        st_m[7] = 1'b1;
      end else if (cmd_m == 8'h20) begin
        if (c == 8'hD0) st_m[7] = 1'b1; else cmd_m = 0;
      end else if (cmd_m == 8'h60) begin
        if (c == 8'hD0 || c == 8'h01) st_m[7] = 1'b1; else cmd_m = 0;
      end else if (cmd_m == 8'h98) begin
        if (c == 8'hFF) cmd_m = 0; else arm_m = 1;
      end else cmd_m = 0;
    end
  endfunction

  function automatic logic [31:0] model_rd(input logic [7:0] a, input logic [1:0] sz);
    int nb;
    logic [31:0] r;
    logic [7:0] b;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    r = 0;
    for (int k = 0; k < nb; k++) begin
      if (cmd_m == 8'h00) b = mem_m[8'(a + k)];
      else if (cmd_m == 8'h90) b = ((a >> 2) == 0) ? MFR[7:0] : ((a >> 2) == 1) ? DID[7:0] : 8'h00;
      else if (cmd_m == 8'h98) b = qry_ref(int'(a >> 2));
      else b = st_m;
      r[k*8 +: 8] = b;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    model_wr(a, d, sz, wp_i);
  endtask

  task automatic rd(input logic [7:0] a, input logic [1:0] sz, input string req);
    logic [31:0] exp;
    exp = model_rd(a, sz);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_req = 0;
    check({req, " rvalid"}, {31'd0, bus_rvalid}, 32'd1);
    check(req, bus_rdata, exp);
  endtask

  function automatic logic [7:0] pick_cmd();
    logic [7:0] list [13];
    list = '{8'hFF, 8'h00, 8'hF0, 8'h10, 8'h40, 8'h20, 8'h50, 8'h60, 8'h70, 8'h90, 8'h98, 8'h33, 8'hE8};
    return list[$urandom % 13];
  endfunction

  logic done;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [1:0] sz;
    int op;
    done = 0; checks = 0; errors = 0;
    void'($urandom(32'd20240611));
    bus_req = 0; bus_we = 0; bus_addr = 0; bus_size = 0; bus_wdata = 0; wp_i = 0;
    cmd_m = 0; arm_m = 0; st_m = 8'h80;
    for (int i = 0; i < 256; i++) mem_m[i] = 8'h00;
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rvalid reset", {31'd0, bus_rvalid}, 32'd0);
    check("R11 rdata reset", bus_rdata, 32'd0);
    rst_n = 1;
    wr(8'h00, 32'h70, 0);
    rd(8'h00, 2, "R11 status after reset");
    check("R6 status replicated", bus_rdata, 32'h80808080);

    // R3 erase all sectors with confirm
    for (int s = 0; s < 16; s++) begin
      wr(8'(s * 16 + 3), 32'h20, 0);
      wr(8'(s * 16), 32'hD0, 0);
    end
    rd(8'h40, 2, "R3 status after confirm");
    wr(8'h00, 32'hFF, 0);
    rd(8'h00, 2, "R3 erased word");
    check("R3 erased value", bus_rdata, 32'hFFFFFFFF);

    // R2 program 4 bytes little-endian
    wr(8'h10, 32'h40, 0);
    wr(8'h10, 32'h11223344, 2);
    rd(8'h10, 2, "R2 status after program");
    wr(8'h00, 32'hF0, 0);
    rd(8'h10, 2, "R2 programmed word");
    check("R2 word value", bus_rdata, 32'h11223344);
    rd(8'h11, 0, "R1 single byte");
    check("R1 byte value", bus_rdata, 32'h00000033);
    wr(8'h30, 32'h10, 0);
    wr(8'hFF, 32'hBEEF, 1);
    wr(8'h00, 32'h00, 0);
    rd(8'hFF, 1, "R1 wrapped halfword");

    // R3 erase abort with unexpected second value
    wr(8'h15, 32'h20, 0);
    wr(8'h15, 32'h12, 0);
    rd(8'h10, 2, "R3 aborted erase reads array");
    check("R3 sector cleared", bus_rdata, 32'hFFFFFFFF);

    // R4 write protect on program and on erase
    wp_i = 1;
    wr(8'h20, 32'h10, 0);
    wr(8'h20, 32'h000000AB, 0);
    rd(8'h20, 2, "R4 program error status");
    check("R4 status value", bus_rdata, 32'h90909090);
    wr(8'h00, 32'hFF, 0);
    rd(8'h20, 0, "R4 array unchanged");
    wr(8'h00, 32'h20, 0);
    wr(8'h00, 32'hD0, 0);
    rd(8'h00, 2, "R4 erase error status");
    wp_i = 0;
    wr(8'h00, 32'hFF, 0);
    rd(8'hFE, 1, "R4 erase blocked");

    // R5 clear status
    wr(8'h00, 32'h50, 0);
    rd(8'hFE, 1, "R5 read array after clear");
    wr(8'h00, 32'h70, 0);
    rd(8'h00, 2, "R5 status cleared");
    check("R5 status zero", bus_rdata, 32'h0);

    // R7 identification
    wr(8'h00, 32'h90, 0);
    rd(8'h00, 1, "R7 manufacturer");
    check("R7 mfr value", bus_rdata, 32'h00008989);
    rd(8'h04, 2, "R7 device");
    rd(8'h08, 2, "R7 other index");

    // R8 query
    wr(8'h00, 32'h98, 0);
    rd(8'h40, 0, "R8 query Q");
    check("R8 Q value", bus_rdata, 32'h51);
    wr(8'h00, 32'h00, 0);
    rd(8'h44, 2, "R8 stays in query");
    rd(8'h9C, 0, "R8 size entry");
    rd(8'hB4, 1, "R8 sector count");
    wr(8'h00, 32'hFF, 0);
    rd(8'h44, 2, "R8 exit to array");

    // R9 lock sequences
    wr(8'h00, 32'h60, 0);
    wr(8'h00, 32'h01, 0);
    rd(8'h00, 2, "R9 lock completes");
    wr(8'h00, 32'h60, 0);
    wr(8'h10, 32'h77, 0);
    rd(8'h10, 2, "R9 bad second value");

    // R10 unrecognised command
    wr(8'h00, 32'h70, 0);
    wr(8'h00, 32'h33, 0);
    rd(8'h10, 2, "R10 unknown command array");
    wr(8'h00, 32'h70, 0);
    rd(8'h00, 0, "R10 status unchanged");

    // random phase
    for (int it = 0; it < 600; it++) begin
      op = $urandom % 8;
      a  = 8'($urandom);
      sz = 2'($urandom % 3);
      wp_i = (($urandom % 6) == 0);
      case (op)
        0: begin wr(a, (($urandom % 2) != 0) ? 32'h10 : 32'h40, 0); wr(a, $urandom, sz); end
        1: begin
          wr(a, 32'h20, 0);
          case ($urandom % 3)
            0: wr(a, 32'hD0, 0);
            1: wr(a, 32'hFF, 0);
            default: wr(a, 32'($urandom % 256), 0);
          endcase
        end
        2: wr(a, {24'd0, pick_cmd()}, 0);
        3: wr(a, 32'($urandom % 256), 0);
        default: begin
          wp_i = 0;
          rd(a, sz, (cmd_m == 0) ? "R1 random array" :
                    (cmd_m == 8'h90) ? "R7 random ident" :
                    (cmd_m == 8'h98) ? "R8 random query" : "R6 random status");
        end
      endcase
    end
    wp_i = 0;
    wr(8'h00, 32'hFF, 0);
    for (int i = 0; i < 64; i++) rd(8'(i * 4), 2, "R2 final array sweep");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule